// File: doc/BRIEF.md
# Link-Change Interrupt Register Block

This block watches a single link-status input, turns every change of that input into a latched interrupt event, and presents the result through three small management registers and an interrupt pin. Software polls or reacts to the pin, reads the status word to learn the live link state and acknowledge the summary flag, and reads the interrupt word to find the source and clear it. The pin has its own polarity, gating enable and output-enable controls.

The summary flag and the pin follow different rules. Reading the status word clears the summary flag. The pin stays asserted as long as an enabled source is still pending. A three-state machine tracks the summary flag. It sits in `ST_QUIET` when nothing is outstanding. It sits in `ST_FLAGGED` while the summary flag is set. It sits in `ST_HELD` once the flag has been acknowledged but an enabled source remains. The transitions are:

- T_RAISE: any state to `ST_FLAGGED` on an enabled event.
- T_ACK: `ST_FLAGGED` to `ST_HELD` on a status read while a source is still pending.
- T_DRAIN: `ST_FLAGGED` to `ST_QUIET` on a status read with nothing pending, and `ST_HELD` to `ST_QUIET` when the pending source goes away.
- T_LATENT: `ST_QUIET` to `ST_HELD` when a source becomes pending without a fresh enabled event, for example when the enable is written after the event.

A clock-enable input qualifies every state change in the block, register accesses included.

Top module: `linkirq_regs`

## Requirements
- R1: After reset all three registers read 0x0000, the pin shows its inactive level for polarity 0 (irq_pin = 1) and irq_oe = 0.
- R2: Status register (address 0x10) bit 0 returns the link_up input after a two-stage synchronizer. Bit 7 returns the summary flag. All other bits read zero.
- R3: A change of the synchronized link level in either direction sets the event flag, bit 13 of the interrupt register (address 0x12). The flag is readable after the third enabled clock edge following the input change.
- R4: The summary flag (status bit 7) sets on an event that arrives while the link-change enable (bit 5 of 0x12) is 1. A read of 0x10 clears it. An enabled event in the same cycle as that read leaves it set.
- R5: A read of 0x12 returns the pre-read value and clears bit 13. An event in the same cycle as that read leaves bit 13 set.
- R6: The interrupt is active when configuration bit 1 (global enable) is 1 and either the summary flag is set or bit 13 and bit 5 of 0x12 are both 1. It stays active after the summary flag is cleared while that pending source remains.
- R7: With configuration bit 3 = 0 the pin is active low; with bit 3 = 1 it is active high. irq_oe equals configuration bit 0.
- R8: In the configuration register (0x11) only bits 3, 1 and 0 are writable. In 0x12 only bit 5 is writable, and bit 13 cannot be written. Writes to 0x10 are ignored. Unwritable bits read zero.
- R9: rdata is registered. It holds the addressed word from the edge that sampled rd_en. Reads of unmapped addresses return 0x0000.
- R10: While clk_en is 0, no register, synchronizer stage or flag changes, and reads and writes have no effect.
- R11: An event that arrives while bit 5 is 0 still sets bit 13 but not the summary flag. Setting bit 5 afterwards activates the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Qualifies every state update |
| link_up | input | 1 | Asynchronous link-status level |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (with clear-on-read side effects) |
| rdata | output | DATA_W | Registered read data |
| irq_pin | output | 1 | Interrupt level, polarity per configuration |
| irq_oe | output | 1 | Output enable for the interrupt pin |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:

- A status read issued in the very cycle a new enabled event lands. A design that clears unconditionally would lose that event.
- The same collision on the interrupt register. A design that clears unconditionally would drop the flag there too.
- The interrupt after the summary flag is acknowledged. A design that ties the pin to the summary flag alone would release the pin too early.
- An event that arrives while masked and is enabled afterwards. A design that gates latching with the enable would lose that event, and one that sets the summary flag on it would raise a spurious summary.
- A frozen clock enable. A leaky design would apply writes or advance the synchronizer while clk_en is low.
- Polarity and output enable, compared on the pins for every combination used.

// File: rtl/linkirq_pkg.sv
package linkirq_pkg;

    localparam int unsigned DATA_W = 16;

    localparam int unsigned STS_LIVE_BIT = 0;
    localparam int unsigned STS_SUM_BIT  = 7;
    localparam int unsigned CFG_POL_BIT  = 3;
    localparam int unsigned CFG_GEN_BIT  = 1;
    localparam int unsigned CFG_OE_BIT   = 0;
    localparam int unsigned INT_FLG_BIT  = 13;
    localparam int unsigned INT_ENA_BIT  = 5;

    localparam logic [DATA_W-1:0] CFG_WMASK =
        (DATA_W'(1) << CFG_POL_BIT) | (DATA_W'(1) << CFG_GEN_BIT) | (DATA_W'(1) << CFG_OE_BIT);
    localparam logic [DATA_W-1:0] INT_WMASK = DATA_W'(1) << INT_ENA_BIT;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_FLAGGED = 2'd1,
        ST_HELD    = 2'd2
    } irq_state_e;

endpackage

// File: rtl/linkirq_sync.sv
module linkirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic din,
    output logic level,
    output logic change
);

    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else if (clk_en) begin
                    chain <= din;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else if (clk_en) begin
                    chain <= {chain[STAGES-2:0], din};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (clk_en) begin
            prev_q <= chain[STAGES-1];
        end
    end

    assign level  = chain[STAGES-1];
    assign change = chain[STAGES-1] ^ prev_q;

endmodule

// File: rtl/linkirq_fsm.sv
module linkirq_fsm
    import linkirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       raise,
    input  logic       ack,
    input  logic       pending,
    output logic       summary,
    output irq_state_e state
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else if (clk_en) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (raise) begin
                    state_d = ST_FLAGGED;        // T_RAISE
                end else if (pending) begin
                    state_d = ST_HELD;           // T_LATENT
                end
            end
            ST_FLAGGED: begin
                if (raise) begin
                    state_d = ST_FLAGGED;        // T_RAISE wins over ack
                end else if (ack) begin
                    state_d = pending ? ST_HELD  // T_ACK
                                      : ST_QUIET; // T_DRAIN
                end
            end
            ST_HELD: begin
                if (raise) begin
                    state_d = ST_FLAGGED;        // T_RAISE
                end else if (!pending) begin
                    state_d = ST_QUIET;          // T_DRAIN
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        summary = (state_q == ST_FLAGGED);
        state   = state_q;
    end

endmodule

// File: rtl/linkirq_regs.sv
module linkirq_regs
    import linkirq_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] STS_ADDR    = ADDR_W'(8'h10),
    parameter logic [ADDR_W-1:0] CFG_ADDR    = ADDR_W'(8'h11),
    parameter logic [ADDR_W-1:0] INT_ADDR    = ADDR_W'(8'h12)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              link_up,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_pin,
    output logic              irq_oe
);

    logic              live;
    logic              evt;
    logic              summary;
    irq_state_e        state;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] ena_q;
    logic              lnk_flag;
    logic              lnk_en;
    logic              cfg_pol;
    logic              cfg_en;
    logic              cfg_oe;
    logic              pending;
    logic              serv_evt;
    logic              wr_cfg;
    logic              wr_int;
    logic              rd_sts;
    logic              rd_int;
    logic              rd_cfg;
    logic              rd_unm;
    logic [DATA_W-1:0] rd_word;
    logic              irq_active;

    linkirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .din    (link_up),
        .level  (live),
        .change (evt)
    );

    always_comb begin
        wr_cfg = clk_en && wr_en && (addr == CFG_ADDR);
        wr_int = clk_en && wr_en && (addr == INT_ADDR);
        rd_sts = clk_en && rd_en && (addr == STS_ADDR);
        rd_cfg = clk_en && rd_en && (addr == CFG_ADDR);
        rd_int = clk_en && rd_en && (addr == INT_ADDR);
        rd_unm = clk_en && rd_en && !(addr == STS_ADDR) && !(addr == CFG_ADDR)
                 && !(addr == INT_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q <= wdata & CFG_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (wr_int) begin
            ena_q <= wdata & INT_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lnk_flag <= 1'b0;
        end else if (clk_en) begin
            if (evt) begin
                lnk_flag <= 1'b1;
            end else if (rd_int) begin
                lnk_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_pol  = cfg_q[CFG_POL_BIT];
        cfg_en   = cfg_q[CFG_GEN_BIT];
        cfg_oe   = cfg_q[CFG_OE_BIT];
        lnk_en   = ena_q[INT_ENA_BIT];
        pending  = lnk_flag && lnk_en;
        serv_evt = evt && lnk_en;
    end

    linkirq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .raise   (serv_evt),
        .ack     (rd_sts),
        .pending (pending),
        .summary (summary),
        .state   (state)
    );

    always_comb begin
        rd_word = '0;
        if (addr == STS_ADDR) begin
            rd_word[STS_LIVE_BIT] = live;
            rd_word[STS_SUM_BIT]  = summary;
        end else if (addr == CFG_ADDR) begin
            rd_word = cfg_q;
        end else if (addr == INT_ADDR) begin
            rd_word              = ena_q;
            rd_word[INT_FLG_BIT] = lnk_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (clk_en && rd_en) begin
            rdata <= rd_word;
        end
    end

    always_comb begin
        irq_active = cfg_en && ((state == ST_FLAGGED) || pending);
        irq_pin    = cfg_pol ? irq_active : !irq_active;
        irq_oe     = cfg_oe;
    end

endmodule

// File: rtl/linkirq_chk.sv
module linkirq_chk
    import linkirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              wr_en,
    input logic              evt,
    input logic              lnk_flag,
    input logic              lnk_en,
    input logic              cfg_en,
    input logic              cfg_pol,
    input logic              summary,
    input logic              rd_sts,
    input logic              rd_int,
    input logic              rd_cfg,
    input logic              rd_unm,
    input logic [DATA_W-1:0] rdata,
    input logic              irq_pin
);

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && evt) |=> lnk_flag);                                     // R3

    AST_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !(evt && lnk_en)) |=> !summary);                        // R4

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_int && !evt) |=> !lnk_flag);                                   // R5

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !wr_en && cfg_en && lnk_flag && lnk_en) |=> (irq_pin == cfg_pol)); // R6

    AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cfg |=> (rdata[DATA_W-1:4] == '0 && rdata[2] == 1'b0));        // R8

    AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unm |=> (rdata == '0));                                         // R9

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(lnk_flag) && $stable(summary) && $stable(rdata))); // R10

    AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && evt && !lnk_en && !summary && !wr_en) |=> !summary);    // R11

endmodule

bind linkirq_regs linkirq_chk u_chk (.*);

// File: tb/linkirq_regs_bench.sv
`timescale 1ns/100ps
module linkirq_regs_bench;

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-compare, 2 link level, 3 pin compare {oe,pin}
        logic [7:0]  addr;
        logic [15:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 41;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 8'h10, 16'h0000, 4'd1},   // R1
        '{2'd1, 8'h11, 16'h0000, 4'd1},   // R1
        '{2'd1, 8'h12, 16'h0000, 4'd1},   // R1
        '{2'd3, 8'h00, 16'h0001, 4'd1},   // R1 pin high, oe low
        '{2'd1, 8'h07, 16'h0000, 4'd9},   // R9 unmapped
        '{2'd0, 8'h11, 16'hFFFF, 4'd8},   // R8
        '{2'd1, 8'h11, 16'h000B, 4'd8},
        '{2'd3, 8'h00, 16'h0002, 4'd7},   // R7 active high, idle
        '{2'd0, 8'h12, 16'hFFFF, 4'd8},
        '{2'd1, 8'h12, 16'h0020, 4'd8},   // R8 flag not writable
        '{2'd0, 8'h10, 16'hFFFF, 4'd8},
        '{2'd1, 8'h10, 16'h0000, 4'd8},   // R8 status read-only
        '{2'd2, 8'h00, 16'h0001, 4'd3},   // R3 rising
        '{2'd1, 8'h10, 16'h0081, 4'd4},   // R4 R2
        '{2'd3, 8'h00, 16'h0003, 4'd6},
        '{2'd1, 8'h10, 16'h0001, 4'd4},   // R4 cleared
        '{2'd3, 8'h00, 16'h0003, 4'd6},   // R6 held
        '{2'd1, 8'h12, 16'h2020, 4'd5},
        '{2'd1, 8'h12, 16'h0020, 4'd5},   // R5 cleared
        '{2'd3, 8'h00, 16'h0002, 4'd6},
        '{2'd0, 8'h12, 16'h0000, 4'd11},
        '{2'd2, 8'h00, 16'h0000, 4'd3},   // R3 falling
        '{2'd1, 8'h10, 16'h0000, 4'd11},  // R11 no summary
        '{2'd3, 8'h00, 16'h0002, 4'd11},
        '{2'd0, 8'h12, 16'h0020, 4'd11},
        '{2'd3, 8'h00, 16'h0003, 4'd11},  // R11 latent enable
        '{2'd1, 8'h10, 16'h0000, 4'd11},
        '{2'd1, 8'h12, 16'h2020, 4'd5},
        '{2'd3, 8'h00, 16'h0002, 4'd6},
        '{2'd0, 8'h11, 16'h0009, 4'd6},
        '{2'd2, 8'h00, 16'h0001, 4'd3},
        '{2'd3, 8'h00, 16'h0002, 4'd6},   // R6 global enable off
        '{2'd0, 8'h11, 16'h000B, 4'd6},
        '{2'd3, 8'h00, 16'h0003, 4'd6},
        '{2'd0, 8'h11, 16'h0003, 4'd7},
        '{2'd3, 8'h00, 16'h0002, 4'd7},   // R7 active low asserted
        '{2'd0, 8'h11, 16'h0002, 4'd7},
        '{2'd3, 8'h00, 16'h0000, 4'd7},   // R7 oe off
        '{2'd1, 8'h10, 16'h0081, 4'd4},
        '{2'd1, 8'h12, 16'h2020, 4'd5},
        '{2'd3, 8'h00, 16'h0001, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        link_up = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rdata;
    logic        irq_pin;
    logic        irq_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    linkirq_regs u_linkirq_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .link_up (link_up),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .irq_pin (irq_pin),
        .irq_oe  (irq_oe)
    );

    task automatic compare(input int req, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d got=%04h expected=%04h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic read_check(input int req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] d;
        do_read(a, d);
        compare(req, d, exp);
    endtask

    task automatic pin_check(input int req, input logic [1:0] exp);
        compare(req, {14'd0, irq_oe, irq_pin}, {14'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            unique case (VEC[i].op)
                2'd0: do_write(VEC[i].addr, VEC[i].val);
                2'd1: read_check(int'(VEC[i].req), VEC[i].addr, VEC[i].val);
                2'd2: begin
                    link_up = VEC[i].val[0];
                    repeat (4) @(negedge clk);
                end
                default: pin_check(int'(VEC[i].req), VEC[i].val[1:0]);
            endcase
        end

        // R5: event lands in the same cycle as the interrupt-register read
        link_up = 1'b0;
        repeat (2) @(negedge clk);
        read_check(5, 8'h12, 16'h0020);
        read_check(5, 8'h12, 16'h2020);
        read_check(4, 8'h10, 16'h0080);

        // R4: enabled event lands in the same cycle as the status read
        link_up = 1'b1;
        repeat (2) @(negedge clk);
        read_check(4, 8'h10, 16'h0001);
        read_check(4, 8'h10, 16'h0081);
        read_check(5, 8'h12, 16'h2020);

        // R10: frozen clock enable blocks writes and synchronizer
        clk_en = 1'b0;
        do_write(8'h11, 16'h000B);
        link_up = 1'b0;
        repeat (6) @(negedge clk);
        clk_en = 1'b1;
        read_check(10, 8'h10, 16'h0001);
        read_check(10, 8'h11, 16'h0002);

        // R1: reset in mid-operation
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pin_check(1, 2'b01);
        read_check(1, 8'h12, 16'h0000);
        read_check(1, 8'h11, 16'h0000);
        read_check(2, 8'h10, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1 watchdog expired got=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule